// File: doc/BRIEF.md
# Tachometer Period Speed Discriminator

This block judges motor speed from the tachometer (FG) signal. It counts the reference-clock ticks, marked by a one-cycle tick enable, that fall between two FG pulses, and compares the result with a target of 512 ticks. The target FG rate is therefore the reference rate divided by 512. Only every other FG period is measured. The period after a measured one is skipped, so one speed result comes out for every two FG cycles.

Each result gives three things. The first is a direction decision: accelerate when the motor is slow, decelerate when it is fast. The second is a signed error equal to the measured count minus the target. The third is an active-low lock flag, which is low while the count lies within ±6.25% of the target (±32 ticks around 512). A one-cycle strobe marks each new result. A run input enables the block. While run is low the block sits idle with neutral outputs, and the first FG pulse after run rises opens a measurement. The FG input must already be synchronized and shortened to a one-cycle pulse.

Top module: `spd_discrim`

## Requirements
- R1: After reset, `lock_n` is 1, `accel` is 0, `err` is 0 and `err_vld` is 0.
- R2: The measured count is the number of cycles with `ref_en` high that come after the pulse that opens the measurement, up to and including the cycle of the closing pulse. Cycles with `ref_en` low do not add to the count.
- R3: FG periods are measured and skipped in turn. The first pulse after run rises opens a measurement. The pulse that closes it opens a skipped period, and the pulse that ends the skipped period opens the next measurement. The end of a skipped period gives no result.
- R4: `err_vld` is high for exactly the one cycle after the closing pulse. In that cycle `err` holds count − TARGET as a CNT_W+1 bit two's complement value. `err` holds this value until the next result.
- R5: `accel` becomes 1 when the count is above TARGET and 0 when it is below TARGET. When the count equals TARGET, `accel` keeps its previous value.
- R6: `lock_n` becomes 0 when the count lies within TARGET ± (TARGET >> TOL_SHIFT), bounds included, and 1 otherwise. It keeps its value between results.
- R7: The count stops at 2^CNT_W − 1. A stopped count is reported as `err` = 2^CNT_W − 1 − TARGET, with `accel` = 1 and `lock_n` = 1.
- R8: While `run` is low, FG pulses are ignored and no result is produced. In the cycle after `run` is seen low, `lock_n` is 1, `accel` is 0 and `err` is 0. After `run` returns high, the next pulse opens a fresh measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables measurement; low forces idle |
| ref_en | input | 1 | Reference tick enable, one per reference clock period |
| fg_pulse | input | 1 | Synchronized one-cycle tachometer pulse |
| accel | output | 1 | 1 = speed up, 0 = slow down |
| err | output | CNT_W+1 | Signed count minus target |
| err_vld | output | 1 | One-cycle strobe for a new result |
| lock_n | output | 1 | 0 while the speed is inside the lock window |

## Verification
The bench builds the block with CNT_W = 6, TARGET = 32 and TOL_SHIFT = 4. This gives a lock window of 30 to 34 ticks and a count that stops at 63. With these values, every period length from 1 to 70 ticks can be swept. The sweep covers every count below, inside and at the edges of the window, the exact-target case where `accel` must hold its value, and the stopped counter. Alternate sweep points thin out `ref_en` with a fixed pattern, and a stop-and-restart episode checks the idle state and the fresh start after run rises again.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MEAS = 2'd1,
    PH_SKIP = 2'd2
  } phase_e;

  // Count step that stops at lim.
  function automatic int sat_step(int v, logic en, int lim);
    if (en && v < lim) return v + 1;
    return v;
  endfunction

  // Signed speed error: positive means slow.
  function automatic int speed_err(int c, int tgt);
    return c - tgt;
  endfunction

  // Inclusive lock window; a stopped count never locks.
  function automatic logic in_lock(int c, int tgt, int tol, int lim);
    return (c != lim) && (c >= tgt - tol) && (c <= tgt + tol);
  endfunction

endpackage

// File: rtl/spd_phase_ctrl.sv
module spd_phase_ctrl
  import spd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   fg_pulse,
  output phase_e phase,
  output logic   open_evt,
  output logic   meas_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
    end else if (!run) begin
      phase <= PH_IDLE;
    end else if (fg_pulse) begin
      case (phase)
        PH_IDLE: phase <= PH_MEAS;
        PH_MEAS: phase <= PH_SKIP;
        PH_SKIP: phase <= PH_MEAS;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign open_evt  = run && fg_pulse && (phase != PH_MEAS);
  assign meas_done = run && fg_pulse && (phase == PH_MEAS);

endmodule

// File: rtl/spd_period_cnt.sv
module spd_period_cnt
  import spd_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             ref_en,
  input  logic             counting,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next
);

  localparam int CNT_MAX = (1 << CNT_W) - 1;

  assign cnt_next = CNT_W'(sat_step(int'(cnt), ref_en, CNT_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || clear) begin
      cnt <= '0;
    end else if (counting) begin
      cnt <= cnt_next;
    end
  end

endmodule

// File: rtl/spd_err_eval.sv
module spd_err_eval
  import spd_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int TARGET    = 512,
  parameter int TOL_SHIFT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                meas_done,
  input  logic [CNT_W-1:0]    cnt_fin,
  output logic                accel,
  output logic signed [CNT_W:0] err,
  output logic                err_vld,
  output logic                lock_n
);

  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int TOL     = TARGET >> TOL_SHIFT;

  int c_val;
  assign c_val = int'(cnt_fin);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accel   <= 1'b0;
      err     <= '0;
      err_vld <= 1'b0;
      lock_n  <= 1'b1;
    end else if (!run) begin
      accel   <= 1'b0;
      err     <= '0;
      err_vld <= 1'b0;
      lock_n  <= 1'b1;
    end else if (meas_done) begin
      err_vld <= 1'b1;
      err     <= (CNT_W+1)'(speed_err(c_val, TARGET));
      if (c_val > TARGET)      accel <= 1'b1;
      else if (c_val < TARGET) accel <= 1'b0;
      lock_n  <= !in_lock(c_val, TARGET, TOL, CNT_MAX);
    end else begin
      err_vld <= 1'b0;
    end
  end

endmodule

// File: rtl/spd_discrim.sv
module spd_discrim
  import spd_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int TARGET    = 512,
  parameter int TOL_SHIFT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  ref_en,
  input  logic                  fg_pulse,
  output logic                  accel,
  output logic signed [CNT_W:0] err,
  output logic                  err_vld,
  output logic                  lock_n
);

  phase_e           phase;
  logic             open_evt;
  logic             meas_done;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_next;

  initial begin
    if (TARGET >= (1 << CNT_W) - 1) $error("TARGET must be below the count limit");
  end

  spd_phase_ctrl u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .fg_pulse (fg_pulse),
    .phase    (phase),
    .open_evt (open_evt),
    .meas_done(meas_done)
  );

  spd_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .ref_en  (ref_en),
    .counting(phase == PH_MEAS),
    .clear   (open_evt || meas_done),
    .cnt     (cnt),
    .cnt_next(cnt_next)
  );

  spd_err_eval #(
    .CNT_W    (CNT_W),
    .TARGET   (TARGET),
    .TOL_SHIFT(TOL_SHIFT)
  ) u_eval (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .meas_done(meas_done),
    .cnt_fin  (cnt_next),
    .accel    (accel),
    .err      (err),
    .err_vld  (err_vld),
    .lock_n   (lock_n)
  );

endmodule

// File: rtl/spd_discrim_chk.sv
module spd_discrim_chk #(
  parameter int CNT_W     = 10,
  parameter int TARGET    = 512,
  parameter int TOL_SHIFT = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  run,
  input logic                  fg_pulse,
  input logic                  accel,
  input logic signed [CNT_W:0] err,
  input logic                  err_vld,
  input logic                  lock_n,
  input logic                  meas_done,
  input logic [CNT_W-1:0]      cnt
);

  localparam int TOL     = TARGET >> TOL_SHIFT;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  // R4
  vld_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> $past(fg_pulse));

  // R3
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |=> !err_vld);

  // R6
  lock_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && !lock_n) |-> (err >= -TOL && err <= TOL));

  // R6
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !err_vld) |-> $stable(lock_n));

  // R5
  accel_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && err > 0) |-> accel);

  // R5
  accel_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && err < 0) |-> !accel);

  // R7
  sat_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_vld && err == CNT_MAX - TARGET) |-> lock_n);

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (lock_n && !accel && !err_vld));

  // R2
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |=> (cnt == '0));

endmodule

bind spd_discrim spd_discrim_chk #(
  .CNT_W    (CNT_W),
  .TARGET   (TARGET),
  .TOL_SHIFT(TOL_SHIFT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .fg_pulse (fg_pulse),
  .accel    (accel),
  .err      (err),
  .err_vld  (err_vld),
  .lock_n   (lock_n),
  .meas_done(meas_done),
  .cnt      (cnt)
);

// File: tb/tb_spd_discrim.sv
module tb_spd_discrim;

  localparam int CW  = 6;
  localparam int TGT = 32;
  localparam int TS  = 4;
  localparam int TOL = TGT >> TS;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic ref_en = 1'b0;
  logic fg_pulse = 1'b0;
  logic accel;
  logic signed [CW:0] err;
  logic err_vld;
  logic lock_n;

  int total = 0;
  int fails = 0;
  logic exp_accel = 1'b0;

  always #4 clk = ~clk;

  spd_discrim #(.CNT_W(CW), .TARGET(TGT), .TOL_SHIFT(TS)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .ref_en(ref_en), .fg_pulse(fg_pulse),
    .accel(accel), .err(err), .err_vld(err_vld), .lock_n(lock_n)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic fg, input logic en);
    fg_pulse = fg;
    ref_en = en;
    @(negedge clk);
    fg_pulse = 1'b0;
  endtask

  // Drive n cycles, closing pulse on the last; return ticks counted.
  task automatic period(input int n, input int mode, output int ticks);
    ticks = 0;
    for (int i = 1; i <= n; i++) begin
      logic en;
      en = (mode == 0) ? 1'b1 : ((i % 3) != 0);
      if (en) ticks++;
      step(i == n, en);
    end
  endtask

  task automatic check_result(input int ticks, input string tag);
    int c;
    int e;
    logic lk;
    c = (ticks > MAXC) ? MAXC : ticks;
    e = c - TGT;
    if (c > TGT) exp_accel = 1'b1;
    else if (c < TGT) exp_accel = 1'b0;
    lk = (c != MAXC) && (c >= TGT - TOL) && (c <= TGT + TOL);
    chk(err_vld == 1'b1, {tag, " R4 strobe"}, int'(err_vld), 1);
    chk(int'(err) == e, {tag, " R2 R4 error value"}, int'(err), e);
    chk(accel == exp_accel, {tag, " R5 accel"}, int'(accel), int'(exp_accel));
    chk(lock_n == !lk, {tag, " R6 lock_n"}, int'(lock_n), int'(!lk));
    step(1'b0, 1'b1);
    chk(err_vld == 1'b0, {tag, " R4 strobe one cycle"}, int'(err_vld), 0);
    chk(int'(err) == e, {tag, " R4 error held"}, int'(err), e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int t;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lock_n == 1'b1, "R1 lock_n", int'(lock_n), 1);
    chk(accel == 1'b0, "R1 accel", int'(accel), 0);
    chk(int'(err) == 0, "R1 err", int'(err), 0);
    chk(err_vld == 1'b0, "R1 err_vld", int'(err_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run = 1'b1;
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);              // opening pulse
    for (int n = 1; n <= 70; n++) begin
      period(n, n % 2, t);
      check_result(t - 0, $sformatf("sweep n=%0d", n));
      // R3 skipped period ends with a pulse that gives no result
      period(3, 0, t);
      chk(err_vld == 1'b0, "R3 skip gives no result", int'(err_vld), 0);
    end
    // R5 equal count holds accel high after a slow result
    period(40, 0, t); check_result(t, "R5 slow before equal");
    period(3, 0, t);
    period(32, 0, t); check_result(t, "R5 equal holds");
    period(3, 0, t);
    // R7 stopped counter with thinned ticks
    period(200, 1, t); check_result(t, "R7 saturated");
    // R8 stop: outputs neutral, pulses ignored
    run = 1'b0;
    step(1'b0, 1'b1);
    chk(lock_n == 1'b1, "R8 lock_n idle", int'(lock_n), 1);
    chk(accel == 1'b0, "R8 accel idle", int'(accel), 0);
    chk(int'(err) == 0, "R8 err idle", int'(err), 0);
    for (int k = 0; k < 6; k++) begin
      step(k % 2 == 0, 1'b1);
      chk(err_vld == 1'b0, "R8 pulses ignored", int'(err_vld), 0);
    end
    // R8 restart: first pulse opens a fresh measurement
    run = 1'b1;
    exp_accel = 1'b0;
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    period(33, 0, t); check_result(t, "R8 restart");
    period(2, 0, t);
    chk(err_vld == 1'b0, "R3 skip after restart", int'(err_vld), 0);
    period(29, 0, t); check_result(t, "R6 below window");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule